// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a memory-mapped general-purpose I/O controller for 64 pins, arranged as two 32-bit banks. For every pin, software sets the direction, picks between plain GPIO use and an alternate function, drives an output value and reads back the input value after synchronization. A pin handed to its alternate function takes its output value and its output enable from that peripheral's signals, which come in as inputs to the block.

The lowest 16 pins can raise interrupts. Each of these pins has three trigger bits: edge select, high/rising and low/falling. Together they choose no interrupt, a level mode or an edge mode. Each pin also has a pending bit, a mask bit and an acknowledge bit. The pending bits, gated by the mask, are ORed into one interrupt line for the system interrupt controller. Software clears a request by raising the acknowledge bit and then lowering it. While the acknowledge bit stays high, the pending bit stays clear.

The register port is a plain single-cycle access with a word address, a write strobe, write data and read data. It has no handshake and no back-pressure. A write is taken at the clock edge while the strobe is high. Read data is combinational from the addressed register.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset, every writable register reads 0, pad_oe is all zero and irq_out is low.
- R2: Register word addresses: 0 IN bank0 (read-only), 1 OUT bank0, 2 DIR bank0, 3 ALT bank0, 4 to 7 the same four registers for bank1, 8 TRIG_EDGE, 9 TRIG_HI, 10 TRIG_LO, 11 PEND (read-only), 12 MASK, 13 ACK. Writable registers read back the value written.
- R3: Pin p maps to bank p/32, bit p%32. With ALT=0, pad_oe equals DIR and pad_out equals OUT. With ALT=1, pad_oe equals alt_oe and pad_out equals alt_out. A GPIO pin with DIR=0 never drives.
- R4: The IN registers return pad_in after exactly two rising clock edges, whatever DIR and ALT hold.
- R5: The trigger bits are EDGE (bit i of word 8), HI (word 9) and LO (word 10). A pin whose three bits are all 0 never becomes pending.
- R6: With EDGE=1, a synchronized 0-to-1 change sets PEND if HI=1, and a 1-to-0 change sets it if LO=1. PEND is visible on the third rising edge after the pad change. The bit then stays set.
- R7: With EDGE=0, PEND follows the level term (HI and pin high) OR (LO and pin low). It updates on the third edge after a pad change.
- R8: While ACK bit i is 1, PEND bit i is 0 on every following edge, and edges seen in that time are lost. After ACK returns to 0, a level-mode pin whose level is still active sets PEND again.
- R9: irq_out is high exactly when some PEND bit and the same MASK bit are both 1. MASK does not change PEND.
- R10: Only pins 0 to 15 can interrupt. The interrupt registers keep 16 bits, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of addressed register |
| pad_in | input | 64 | Raw pin input values |
| pad_out | output | 64 | Pin output values |
| pad_oe | output | 64 | Pin output enables |
| alt_out | input | 64 | Alternate-function output values |
| alt_oe | input | 64 | Alternate-function output enables |
| irq_out | output | 1 | Aggregated interrupt request |

## Verification
Register writes and the pad_out/pad_oe values that follow from them take effect on the edge that takes the write. The IN value is due two rising edges after a pad change, PEND three edges after, and irq_out changes in the same cycle as PEND or MASK. The bench drives inputs on the falling edge, counts the exact number of rising edges, and samples one time unit after the counted edge, or half a cycle later for reads. For IN and PEND it checks both the edge before the new value is due, where the old value must still show, and the edge on which the new value is due.

// File: rtl/gpio_ctrl_pkg.sv
package gpio_ctrl_pkg;
  localparam int IDX_W       = 4;
  localparam int BANK_STRIDE = 4;

  // Offsets inside one bank window
  localparam int OFS_IN  = 0;
  localparam int OFS_OUT = 1;
  localparam int OFS_DIR = 2;
  localparam int OFS_ALT = 3;

  typedef enum logic [IDX_W-1:0] {
    RX_IN0   = 4'd0,
    RX_OUT0  = 4'd1,
    RX_DIR0  = 4'd2,
    RX_ALT0  = 4'd3,
    RX_IN1   = 4'd4,
    RX_OUT1  = 4'd5,
    RX_DIR1  = 4'd6,
    RX_ALT1  = 4'd7,
    RX_TEDGE = 4'd8,
    RX_THI   = 4'd9,
    RX_TLO   = 4'd10,
    RX_PEND  = 4'd11,
    RX_MASK  = 4'd12,
    RX_ACK   = 4'd13
  } reg_idx_e;

  typedef struct packed {
    logic edge_sel;
    logic hi;
    logic lo;
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) begin
        stage_q[k] <= stage_q[k-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int W = 64
) (
  input  logic [W-1:0] out_val,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] alt_sel,
  input  logic [W-1:0] alt_out,
  input  logic [W-1:0] alt_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (alt_sel[p]) begin
        pad_out[p] = alt_out[p];
        pad_oe[p]  = alt_oe[p];
      end else begin
        pad_out[p] = out_val[p];
        pad_oe[p]  = dir[p];
      end
    end
  end
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell
  import gpio_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_s,
  input  trig_cfg_t cfg,
  input  logic      ack,
  output logic      pend
);
  logic prev_q;
  logic pend_q;
  logic hit_edge;
  logic hit_level;

  always_comb begin
    hit_edge  = (cfg.hi & pin_s & ~prev_q) | (cfg.lo & ~pin_s & prev_q);
    hit_level = (cfg.hi & pin_s) | (cfg.lo & ~pin_s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (ack)
        pend_q <= 1'b0;
      else if (cfg.edge_sel)
        pend_q <= pend_q | hit_edge;
      else
        pend_q <= hit_level;
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_ctrl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NBANK       = 2,
  parameter int NIRQ        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [IDX_W-1:0]        reg_addr,
  input  logic                    reg_we,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic [DATA_W-1:0]       reg_rdata,
  input  logic [DATA_W*NBANK-1:0] pad_in,
  output logic [DATA_W*NBANK-1:0] pad_out,
  output logic [DATA_W*NBANK-1:0] pad_oe,
  input  logic [DATA_W*NBANK-1:0] alt_out,
  input  logic [DATA_W*NBANK-1:0] alt_oe,
  output logic                    irq_out
);
  localparam int NPINS = DATA_W * NBANK;
  localparam int PAD_W = DATA_W - NIRQ;

  logic [NPINS-1:0] out_q, dir_q, alt_q;
  logic [NPINS-1:0] pin_sync;
  logic [NIRQ-1:0]  trig_edge_q, trig_hi_q, trig_lo_q;
  logic [NIRQ-1:0]  irq_mask_q, irq_ack_q;
  logic [NIRQ-1:0]  irq_pend;

  // Register writes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= '0;
      dir_q       <= '0;
      alt_q       <= '0;
      trig_edge_q <= '0;
      trig_hi_q   <= '0;
      trig_lo_q   <= '0;
      irq_mask_q  <= '0;
      irq_ack_q   <= '0;
    end else if (reg_we) begin
      for (int b = 0; b < NBANK; b++) begin
        if (int'(reg_addr) == b*BANK_STRIDE + OFS_OUT) out_q[b*DATA_W +: DATA_W] <= reg_wdata;
        if (int'(reg_addr) == b*BANK_STRIDE + OFS_DIR) dir_q[b*DATA_W +: DATA_W] <= reg_wdata;
        if (int'(reg_addr) == b*BANK_STRIDE + OFS_ALT) alt_q[b*DATA_W +: DATA_W] <= reg_wdata;
      end
      case (reg_addr)
        RX_TEDGE: trig_edge_q <= reg_wdata[NIRQ-1:0];
        RX_THI:   trig_hi_q   <= reg_wdata[NIRQ-1:0];
        RX_TLO:   trig_lo_q   <= reg_wdata[NIRQ-1:0];
        RX_MASK:  irq_mask_q  <= reg_wdata[NIRQ-1:0];
        RX_ACK:   irq_ack_q   <= reg_wdata[NIRQ-1:0];
        default: ;
      endcase
    end
  end

  // Register readback
  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (int'(reg_addr) == b*BANK_STRIDE + OFS_IN)  reg_rdata = pin_sync[b*DATA_W +: DATA_W];
      if (int'(reg_addr) == b*BANK_STRIDE + OFS_OUT) reg_rdata = out_q[b*DATA_W +: DATA_W];
      if (int'(reg_addr) == b*BANK_STRIDE + OFS_DIR) reg_rdata = dir_q[b*DATA_W +: DATA_W];
      if (int'(reg_addr) == b*BANK_STRIDE + OFS_ALT) reg_rdata = alt_q[b*DATA_W +: DATA_W];
    end
    case (reg_addr)
      RX_TEDGE: reg_rdata = {{PAD_W{1'b0}}, trig_edge_q};
      RX_THI:   reg_rdata = {{PAD_W{1'b0}}, trig_hi_q};
      RX_TLO:   reg_rdata = {{PAD_W{1'b0}}, trig_lo_q};
      RX_PEND:  reg_rdata = {{PAD_W{1'b0}}, irq_pend};
      RX_MASK:  reg_rdata = {{PAD_W{1'b0}}, irq_mask_q};
      RX_ACK:   reg_rdata = {{PAD_W{1'b0}}, irq_ack_q};
      default: ;
    endcase
  end

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_pad_mux #(.W(NPINS)) u_mux (
    .out_val (out_q),
    .dir     (dir_q),
    .alt_sel (alt_q),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    trig_cfg_t cfg;
    assign cfg = '{edge_sel: trig_edge_q[i], hi: trig_hi_q[i], lo: trig_lo_q[i]};
    gpio_irq_cell u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .pin_s (pin_sync[i]),
      .cfg   (cfg),
      .ack   (irq_ack_q[i]),
      .pend  (irq_pend[i])
    );
  end

  assign irq_out = |(irq_pend & irq_mask_q);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int NPINS = 64,
  parameter int NIRQ  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] dir,
  input logic [NPINS-1:0] alt_sel,
  input logic [NIRQ-1:0]  pend,
  input logic [NIRQ-1:0]  mask,
  input logic [NIRQ-1:0]  ack,
  input logic [NIRQ-1:0]  t_edge,
  input logic [NIRQ-1:0]  t_hi,
  input logic [NIRQ-1:0]  t_lo
);
  // R3
  idle_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~alt_sel & ~dir) == '0);

  // R8
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((pend & $past(ack)) == '0));

  // R6
  edge_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & t_edge & ~ack) != '0) |=>
      ((pend & $past(pend & t_edge & ~ack)) == $past(pend & t_edge & ~ack)));

  // R5
  no_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(t_edge | t_hi | t_lo)) == '0));

  // R9
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq_out);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend != '0));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NPINS(NPINS), .NIRQ(NIRQ)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_out (irq_out),
  .pad_oe  (pad_oe),
  .dir     (dir_q),
  .alt_sel (alt_q),
  .pend    (irq_pend),
  .mask    (irq_mask_q),
  .ack     (irq_ack_q),
  .t_edge  (trig_edge_q),
  .t_hi    (trig_hi_q),
  .t_lo    (trig_lo_q)
);

// File: tb/gpio_ctrl_test.sv
module gpio_ctrl_test;
  import gpio_ctrl_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] pad_in = '0;
  logic [63:0] pad_out, pad_oe;
  logic [63:0] alt_out = '0, alt_oe = '0;
  logic        irq_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
    .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic set_pads(input logic [63:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  function automatic logic [63:0] exp_oe(logic [63:0] d, logic [63:0] a, logic [63:0] aoe);
    return (d & ~a) | (a & aoe);
  endfunction

  function automatic logic [63:0] exp_out(logic [63:0] o, logic [63:0] a, logic [63:0] ao);
    return (o & ~a) | (a & ao);
  endfunction

  function automatic logic [15:0] lvl_of(logic [15:0] e, logic [15:0] h, logic [15:0] l, logic [15:0] s);
    return ~e & ((h & s) | (l & ~s));
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++; fails++;
    $display("FAIL watchdog act=hung exp=finished");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [63:0] o, d, a, pv;
    logic [15:0] e, h, l, t, m, ex;
    logic [3:0]  zero_regs [11];
    r = $urandom(32'h5EED1234);
    zero_regs = '{RX_OUT0, RX_DIR0, RX_ALT0, RX_OUT1, RX_DIR1, RX_ALT1,
                  RX_TEDGE, RX_THI, RX_TLO, RX_MASK, RX_ACK};
    ticks(3);
    rst_n = 1'b1;
    ticks(1);

    // R1 reset state
    foreach (zero_regs[k]) begin
      rd(zero_regs[k], r);
      chk("R1 reset reg", {32'b0, r}, 64'h0);
    end
    chk("R1 pad_oe", pad_oe, 64'h0);
    chk("R1 irq_out", {63'b0, irq_out}, 64'h0);

    // R2 R3 random bank configuration
    for (int it = 0; it < 20; it++) begin
      o = {$urandom, $urandom}; d = {$urandom, $urandom}; a = {$urandom, $urandom};
      if (it == 0) a = '0;
      if (it == 1) a = '1;
      @(negedge clk);
      alt_out = {$urandom, $urandom}; alt_oe = {$urandom, $urandom};
      wr(RX_OUT0, o[31:0]);  wr(RX_DIR0, d[31:0]);  wr(RX_ALT0, a[31:0]);
      wr(RX_OUT1, o[63:32]); wr(RX_DIR1, d[63:32]); wr(RX_ALT1, a[63:32]);
      chk("R3 pad_oe", pad_oe, exp_oe(d, a, alt_oe));
      chk("R3 pad_out", pad_out, exp_out(o, a, alt_out));
      rd(RX_DIR1, r); chk("R2 dir bank1 readback", {32'b0, r}, {32'b0, d[63:32]});
      rd(RX_OUT0, r); chk("R2 out bank0 readback", {32'b0, r}, {32'b0, o[31:0]});
      rd(RX_ALT1, r); chk("R2 alt bank1 readback", {32'b0, r}, {32'b0, a[63:32]});
    end

    // R4 input sampling, regardless of direction
    wr(RX_DIR0, 32'hFFFF_FFFF); wr(RX_DIR1, 32'hFFFF_FFFF);
    for (int it = 0; it < 10; it++) begin
      pv = {$urandom, $urandom};
      set_pads(pv);
      ticks(2);
      rd(RX_IN0, r); chk("R4 in bank0", {32'b0, r}, {32'b0, pv[31:0]});
      rd(RX_IN1, r); chk("R4 in bank1", {32'b0, r}, {32'b0, pv[63:32]});
    end
    set_pads(64'h0); ticks(3);
    set_pads(64'hA5A5_0000_0000_5A5A);
    ticks(1);
    rd(RX_IN0, r); chk("R4 in not yet after one edge", {32'b0, r}, 64'h0);
    ticks(1);
    rd(RX_IN0, r); chk("R4 in after two edges", {32'b0, r}, 64'h5A5A);
    rd(RX_IN1, r); chk("R4 in bank1 after two edges", {32'b0, r}, 64'hA5A5_0000);

    // R10 interrupt registers are 16 bits
    wr(RX_TEDGE, 32'hFFFF_FFFF);
    rd(RX_TEDGE, r); chk("R10 trigger width", {32'b0, r}, 64'h0000_FFFF);

    // R5 R6 R7 R9 random trigger modes
    for (int it = 0; it < 12; it++) begin
      e = 16'($urandom); h = 16'($urandom); l = 16'($urandom); m = 16'($urandom);
      set_pads(64'h0); ticks(3);
      wr(RX_MASK, 32'h0); wr(RX_ACK, 32'hFFFF);
      wr(RX_TEDGE, {16'b0, e}); wr(RX_THI, {16'b0, h}); wr(RX_TLO, {16'b0, l});
      wr(RX_ACK, 32'h0);
      ticks(2);
      ex = lvl_of(e, h, l, 16'h0);
      rd(RX_PEND, r); chk("R7 level with pins low", {32'b0, r}, {48'b0, ex});
      t = 16'($urandom);
      set_pads({16'($urandom), 32'($urandom), t});
      ticks(4);
      ex = (e & h & t) | lvl_of(e, h, l, t);
      rd(RX_PEND, r); chk("R6 R7 R5 after rise", {32'b0, r}, {48'b0, ex});
      wr(RX_MASK, {16'b0, m});
      chk("R9 irq gated by mask", {63'b0, irq_out}, {63'b0, |(ex & m)});
      rd(RX_PEND, r); chk("R9 mask leaves pend", {32'b0, r}, {48'b0, ex});
      set_pads({16'($urandom), 32'($urandom), 16'h0});
      ticks(4);
      ex = (e & (ex | (l & t))) | lvl_of(e, h, l, 16'h0);
      rd(RX_PEND, r); chk("R6 R7 R10 after fall", {32'b0, r}, {48'b0, ex});
    end

    // R6 exact latency of an edge event
    set_pads(64'h0);
    wr(RX_MASK, 32'h0); wr(RX_ACK, 32'hFFFF);
    wr(RX_TEDGE, 32'h1); wr(RX_THI, 32'h1); wr(RX_TLO, 32'h0);
    ticks(3);
    wr(RX_ACK, 32'h0);
    ticks(1);
    set_pads(64'h1);
    ticks(2);
    rd(RX_PEND, r); chk("R6 pend not yet at edge two", {32'b0, r}, 64'h0);
    ticks(1);
    rd(RX_PEND, r); chk("R6 pend at edge three", {32'b0, r}, 64'h1);
    set_pads(64'h0); ticks(4);
    rd(RX_PEND, r); chk("R6 sticky after pin returns", {32'b0, r}, 64'h1);

    // R8 held acknowledge
    wr(RX_ACK, 32'hFFFF);
    wr(RX_TEDGE, 32'h0008); wr(RX_THI, 32'h0028); wr(RX_TLO, 32'h0);
    wr(RX_ACK, 32'h0);
    ticks(3);
    rd(RX_PEND, r); chk("R7 level pin idle", {32'b0, r}, 64'h0);
    set_pads(64'h28); ticks(4);
    rd(RX_PEND, r); chk("R6 R7 both pending", {32'b0, r}, 64'h28);
    wr(RX_MASK, 32'h28);
    chk("R9 irq high", {63'b0, irq_out}, 64'h1);
    wr(RX_ACK, 32'h28);
    ticks(1);
    rd(RX_PEND, r); chk("R8 ack clears", {32'b0, r}, 64'h0);
    chk("R8 irq low after ack", {63'b0, irq_out}, 64'h0);
    set_pads(64'h20); ticks(4);
    set_pads(64'h28); ticks(4);
    rd(RX_PEND, r); chk("R8 no latch while held", {32'b0, r}, 64'h0);
    wr(RX_ACK, 32'h0);
    ticks(2);
    rd(RX_PEND, r); chk("R8 level reasserts, edge lost", {32'b0, r}, 64'h20);
    wr(RX_MASK, 32'h08);
    chk("R9 masked pend gives no irq", {63'b0, irq_out}, 64'h0);

    summary();
  end
endmodule